// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This block is the integer execution stage of a 32-bit processor datapath. In the same cycle it turns an operation code, a first operand and a second operand into a result. The operations are add, subtract, their carry-chained forms, three bitwise logic functions and three shifts. The second operand is either a register value or a short signed immediate that is widened to the datapath width.

The block keeps a four-bit condition flag group in a register: negative, zero, overflow and carry. A per-operation update enable loads new flag values on the next clock edge. When the enable is low, or when the operation is a shift, the stored flags keep their value. The stored carry feeds the carry-chained add and subtract, so that one wide number can be processed as a series of narrower words.

Top module: `int_exec_unit`

## Requirements
- R1: When `use_imm_i` is 1, operand 2 is `imm_i` sign-extended to the datapath width. When it is 0, operand 2 is `rs2_i`.
- R2: `result_o` is combinational. Operation codes: 0 add (op1+op2), 2 subtract (op1-op2), 4 AND, 5 OR, 6 XOR. Results wrap modulo 2^WIDTH.
- R3: Code 1 (add with carry) gives op1+op2+C. Code 3 (subtract with carry) gives op1-op2-C. C is the stored carry flag, `flags_o[0]`.
- R4: Shifts use only the low log2(WIDTH) bits of operand 2 as the count. Code 7 shifts left, code 8 shifts right and fills with zeros, code 9 shifts right and copies the sign bit.
- R5: `flags_o` is {N,Z,V,C} at bits 3..0. An arithmetic operation (codes 0-3) with `set_cc_i`=1 updates the flags at the next rising edge. N is set to the result MSB, and Z is set when the result is all zeros.
- R6: On an add, V is set when both addends have the same sign and the sum has the other sign. On a subtract, V is set when the operands differ in sign and the result sign differs from the sign of op1.
- R7: On an add, C is the unsigned carry out. On a subtract, C is the unsigned borrow, which is set when op1 < op2 + carry-in.
- R8: A logic operation (codes 4-6) with `set_cc_i`=1 sets N and Z from the result and clears V and C.
- R9: The flags keep their value when `set_cc_i`=0, for every shift, and for the unused codes 10-15. The unused codes give a result of zero.
- R10: A synchronous active-high `rst` clears the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| set_cc_i | input | 1 | Flag update enable for this operation |
| use_imm_i | input | 1 | Selects the immediate as operand 2 |
| rs1_i | input | WIDTH | Operand 1 |
| rs2_i | input | WIDTH | Register operand 2 |
| imm_i | input | IMM_W | Signed immediate |
| result_o | output | WIDTH | Operation result |
| flags_o | output | 4 | Stored flags {N,Z,V,C} |

## Verification
The bench uses an 8-bit datapath. Every value of operand 1 is combined with a set of operand-2 values that includes 0, 1, the largest positive, the most negative and all ones. For each pair it runs all four add and subtract forms. This separates carry from overflow and borrow from sign, and the chained forms use whatever carry the previous step left. Logic operations run over the same pairs to show that V and C are cleared. Shifts use counts beyond the count width to show the masking, and they distinguish zero fill from sign fill while the flags must stay fixed. The bench also sweeps every immediate and sends operations with the update enable low and the unused codes.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHRL = 4'd8,
    OP_SHRA = 4'd9
  } ieu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  function automatic logic op_is_arith(input logic [3:0] op);
    return op <= 4'd3;
  endfunction

  function automatic logic op_is_logic(input logic [3:0] op);
    return (op >= 4'd4) && (op <= 4'd6);
  endfunction

  function automatic logic op_is_shift(input logic [3:0] op);
    return (op >= 4'd7) && (op <= 4'd9);
  endfunction
endpackage

// File: rtl/ieu_opnd_sel.sv
module ieu_opnd_sel #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_imm,
  input  logic [WIDTH-1:0] reg_val,
  input  logic [IMM_W-1:0] imm_val,
  output logic [WIDTH-1:0] opnd
);
  localparam int EXT_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_noext
      assign imm_ext = imm_val[WIDTH-1:0];
    end
  endgenerate

  assign opnd = use_imm ? imm_ext : reg_val;

  // R1: the upper operand bits copy the immediate sign bit
  p_imm_sign_r1: assert property (@(posedge clk) disable iff (rst)
    use_imm |-> (opnd[WIDTH-1] == imm_val[IMM_W-1]) && (opnd[IMM_W-1:0] == imm_val));
endmodule

// File: rtl/ieu_addsub.sv
module ieu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             chain,
  input  logic             c_flag,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             v_out
);
  logic [WIDTH-1:0] b_eff;
  logic             cin_raw;
  logic             cin;
  logic [WIDTH:0]   ext;

  always_comb begin
    cin_raw = chain & c_flag;
    b_eff   = sub ? ~b : b;
    // a - b - br == a + ~b + (1 - br)
    cin     = sub ? ~cin_raw : cin_raw;
    ext     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    sum     = ext[WIDTH-1:0];
    c_out   = sub ? ~ext[WIDTH] : ext[WIDTH];
    v_out   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  end
endmodule

// File: rtl/ieu_logic_shift.sv
module ieu_logic_shift #(
  parameter int WIDTH = 32,
  parameter int SH_W  = 5
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SH_W-1:0]  shamt,
  output logic [WIDTH-1:0] y
);
  import ieu_pkg::*;

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << shamt;
      OP_SHRL: y = a >> shamt;
      OP_SHRA: y = WIDTH'($signed(a) >>> shamt);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ieu_flag_reg.sv
module ieu_flag_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic [3:0] nzvc_new,
  output logic [3:0] flags
);
  always_ff @(posedge clk) begin
    if (rst)      flags <= 4'b0000;
    else if (upd) flags <= nzvc_new;
  end

  // R9: without an update request the flags hold
  p_hold_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags));

  // R10: reset clears the flags
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (flags == 4'b0000));
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic             set_cc_i,
  input  logic             use_imm_i,
  input  logic [WIDTH-1:0] rs1_i,
  input  logic [WIDTH-1:0] rs2_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_o
);
  import ieu_pkg::*;

  localparam int SH_W = $clog2(WIDTH);

  logic [WIDTH-1:0] op2;
  logic [WIDTH-1:0] as_sum;
  logic             as_c;
  logic             as_v;
  logic [WIDTH-1:0] ls_y;
  logic             arith;
  logic             logic_op;
  logic             is_sub;
  logic             is_chain;
  logic             res_zero;
  logic [3:0]       nzvc_new;
  logic             flag_upd;

  assign arith    = op_is_arith(op_i);
  assign logic_op = op_is_logic(op_i);
  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_SUBC);
  assign is_chain = (op_i == OP_ADDC) || (op_i == OP_SUBC);

  ieu_opnd_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .use_imm (use_imm_i),
    .reg_val (rs2_i),
    .imm_val (imm_i),
    .opnd    (op2)
  );

  ieu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a      (rs1_i),
    .b      (op2),
    .sub    (is_sub),
    .chain  (is_chain),
    .c_flag (flags_o[FLAG_C]),
    .sum    (as_sum),
    .c_out  (as_c),
    .v_out  (as_v)
  );

  ieu_logic_shift #(.WIDTH(WIDTH), .SH_W(SH_W)) u_ls (
    .op    (op_i),
    .a     (rs1_i),
    .b     (op2),
    .shamt (op2[SH_W-1:0]),
    .y     (ls_y)
  );

  assign result_o = arith ? as_sum : ls_y;
  assign res_zero = (result_o == '0);

  always_comb begin
    nzvc_new[FLAG_N] = result_o[WIDTH-1];
    nzvc_new[FLAG_Z] = res_zero;
    nzvc_new[FLAG_V] = arith & as_v;
    nzvc_new[FLAG_C] = arith & as_c;
  end

  assign flag_upd = set_cc_i & (arith | logic_op);

  ieu_flag_reg u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd      (flag_upd),
    .nzvc_new (nzvc_new),
    .flags    (flags_o)
  );

  // R5: N after a flag-setting arithmetic op equals the result MSB
  p_neg_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (set_cc_i && op_is_arith(op_i)) |=> (flags_o[FLAG_N] == $past(result_o[WIDTH-1])));

  // R8: logic ops with update clear V and C
  p_logic_clear_vc_r8: assert property (@(posedge clk) disable iff (rst)
    (set_cc_i && op_is_logic(op_i)) |=> (flags_o[1:0] == 2'b00));

  // R9: shifts never touch the flags
  p_shift_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
    op_is_shift(op_i) |=> $stable(flags_o));

  // R9: unused codes give zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd10) |-> (result_o == '0));
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  localparam int W  = 8;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    op;
  logic          set_cc;
  logic          use_imm;
  logic [W-1:0]  rs1;
  logic [W-1:0]  rs2;
  logic [IW-1:0] imm;
  logic [W-1:0]  result;
  logic [3:0]    flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags;

  always #2.5 clk = ~clk;

  int_exec_unit #(.WIDTH(W), .IMM_W(IW)) u0 (
    .clk(clk), .rst(rst), .op_i(op), .set_cc_i(set_cc), .use_imm_i(use_imm),
    .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm), .result_o(result), .flags_o(flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model: returns result, updates mflags
  function automatic int model(input int o, input int a, input int b, input bit cc);
    int r, s, c, v, sa, sb, sr;
    bit shf;
    int cin = mflags[0];
    r = 0; c = 0; v = 0; shf = 0;
    sa = (a >> 7) & 1; sb = (b >> 7) & 1;
    case (o)
      0, 1: begin
        s = a + b + ((o == 1) ? cin : 0);
        r = s & 255; c = (s > 255); sr = (r >> 7) & 1;
        v = (sa == sb) && (sr != sa);
      end
      2, 3: begin
        int bc = b + ((o == 3) ? cin : 0);
        r = (a - bc) & 255; c = (a < bc); sr = (r >> 7) & 1;
        v = (sa != sb) && (sr != sa);
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: begin r = (a << (b & 7)) & 255; shf = 1; end
      8: begin r = a >> (b & 7); shf = 1; end
      9: begin r = ((sa ? (a | 32'hFFFFFF00) : a) >>> (b & 7)) & 255; shf = 1; end
      default: r = 0;
    endcase
    if (cc && o <= 6 && !shf)
      mflags = {r[7], (r == 0), v[0], c[0]};
    return r;
  endfunction

  // starts and ends at a negedge
  task automatic run(input string req, input int o, input int a, input int b,
                     input bit cc, input bit imm_sel, input int iv);
    int eb, exp;
    op = 4'(o); rs1 = W'(a); rs2 = W'(b); set_cc = cc; use_imm = imm_sel; imm = IW'(iv);
    eb = imm_sel ? (((iv >> (IW-1)) & 1) ? (iv | 32'hFFFFFFC0) & 255 : iv & 63) : b;
    exp = model(o, a, eb, cc);
    #1;
    chk(req, int'(result), exp);
    @(negedge clk);
    chk({req, " flags"}, int'(flags), int'(mflags));
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bl [12] = '{0, 1, 2, 8'h7f, 8'h80, 8'h81, 8'hff, 8'hfe, 8'h55, 8'haa, 8'h40, 8'h0f};
    rst = 1; op = 0; set_cc = 0; use_imm = 0; rs1 = 0; rs2 = 0; imm = 0;
    mflags = 4'b0000;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R10 reset flags", int'(flags), 0);

    // R2 R3 R5 R6 R7 arithmetic sweep
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 4; o++)
          run("R2/R3/R5/R6/R7 arith", o, a, bl[j], 1'b1, 1'b0, 0);

    // R8 logic sweep
    for (int a = 0; a < 256; a += 3)
      for (int j = 0; j < 12; j++)
        for (int o = 4; o < 7; o++)
          run("R2/R8 logic", o, a, bl[j], 1'b1, 1'b0, 0);

    // R4 R9 shifts with counts beyond range, flags set nonzero first
    run("R5 prep", 2, 0, 1, 1'b1, 1'b0, 0);
    for (int j = 0; j < 12; j++)
      for (int s = 0; s < 16; s++)
        for (int o = 7; o < 10; o++)
          run("R4/R9 shift", o, bl[j], s, 1'b1, 1'b0, 0);

    // R9 no update when set_cc low, and unused codes
    for (int a = 0; a < 256; a += 17)
      for (int o = 0; o < 16; o++)
        run("R9 hold", o, a, 8'h91, (o >= 10), 1'b0, 0);

    // R1 immediate sweep
    for (int i = 0; i < 64; i++) begin
      run("R1 imm add", 0, 0, 8'h33, 1'b0, 1'b1, i);
      run("R1 imm xor", 6, 8'h5a, 8'h00, 1'b1, 1'b1, i);
    end

    // R10 mid-run reset
    run("R5 prep", 2, 0, 1, 1'b1, 1'b0, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    mflags = 4'b0000;
    chk("R10 reset clears", int'(flags), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule